// File: doc/BRIEF.md
# Command-Driven Buffer Access Port

This block lets a host processor stream 16-bit words into or out of a descriptor buffer RAM through one narrow port. Every host cycle is either a command cycle, whose low byte is an opcode, or a data cycle. Register opcodes pick a small register for the data cycles that follow. Buffer opcodes start a burst: each matching data cycle moves one word, and an internal byte pointer steps by two.

Before a burst, the host loads a byte count. When the pointer reaches that count, the burst ends. A sticky end-of-transfer interrupt is raised, and a status register records which direction completed. After that, data cycles are ignored until the next command. Any command clears the pointer and drops an unfinished burst without raising the interrupt.

Top module: `bap_port`

## Requirements
- R1: After reset, `eot_irq` and `io_rvalid` are 0, the count register reads 0 and the status register reads 0.
- R2: Opcode 0xA2 followed by a data write loads the byte count from the low 10 bits of the data. Opcode 0x22 followed by a data read returns the count, zero-extended.
- R3: Opcode 0xC4 starts a write burst that stores successive data writes at word addresses 0, 1, 2 and so on. Opcode 0x44 starts a read burst that returns those words in the same order. Each accepted read sets `io_rvalid` with the word one clock after the strobe.
- R4: Each accepted burst access advances the byte pointer by 2. An odd count finishes on the access that covers its last byte, so a count of 5 takes exactly 3 accesses.
- R5: The accepted access that reaches the count sets `eot_irq`. It also sets status bit 1 for a write burst or status bit 0 for a read burst. Opcode 0x26 followed by a data read returns the status. Opcodes 0x44 and 0xC4 clear both status bits.
- R6: Data accesses after the count is reached are ignored. A read gives no `io_rvalid`, a write changes no RAM word, and the pointer does not wrap.
- R7: `eot_irq` stays set until opcode 0xA4 is followed by a data write with bit 0 equal to 1. A write with bit 0 equal to 0 leaves it set. Opcode 0x24 followed by a read returns the flag in bit 0.
- R8: Any command resets the pointer to 0 and abandons an unfinished burst without setting `eot_irq`. A new burst starts again at word 0.
- R9: A data access in the direction opposite to the current burst is ignored and does not move the pointer. With a count of 0, no burst access is accepted and `eot_irq` stays 0.
- R10: Data accesses after an unknown opcode, or after no command since reset, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_valid | input | 1 | Host strobe, one cycle per access |
| io_cmd | input | 1 | 1: command cycle (opcode in io_wdata[7:0]), 0: data cycle |
| io_we | input | 1 | Data cycle direction, 1 = host write |
| io_wdata | input | 16 | Opcode or write data |
| io_rdata | output | 16 | Read data, valid while io_rvalid is 1 |
| io_rvalid | output | 1 | Read data returned, one clock after an accepted read |
| eot_irq | output | 1 | Sticky end-of-transfer interrupt |

## Verification
The bench uses odd and even counts. A design that rounded the count the wrong way would raise the interrupt one word early or one word late. It sends extra accesses after completion and then reads back a word placed earlier. A pointer that wrapped would overwrite that word or return unexpected read data. It aborts a burst in the middle and restarts it, which exposes a stale pointer or a spurious interrupt. It also issues wrong-direction accesses, a zero count and unknown opcodes, any of which a loose decoder would accept as data.

// File: rtl/bap_pkg.sv
`timescale 1ns/1ps
package bap_pkg;
  typedef enum logic [2:0] {M_IDLE, M_RD_BUF, M_WR_BUF, M_REG_RD, M_REG_WR} mode_e;
  typedef enum logic [1:0] {SEL_CNT, SEL_IRQ, SEL_STAT, SEL_NONE} reg_e;

  // base opcodes; bit 7 of the opcode marks the write form
  localparam logic [6:0] OP_BUF  = 7'h44;
  localparam logic [6:0] OP_CNT  = 7'h22;
  localparam logic [6:0] OP_IRQ  = 7'h24;
  localparam logic [6:0] OP_STAT = 7'h26;
endpackage

// File: rtl/bap_cmd_decode.sv
`timescale 1ns/1ps
module bap_cmd_decode
  import bap_pkg::*;
(
  input  logic [7:0] code,
  output mode_e      mode,
  output reg_e       sel
);
  logic wr_form;
  assign wr_form = code[7];

  always_comb begin
    mode = M_IDLE;
    sel  = SEL_NONE;
    case (code[6:0])
      OP_BUF:  mode = wr_form ? M_WR_BUF : M_RD_BUF;
      OP_CNT:  begin mode = wr_form ? M_REG_WR : M_REG_RD; sel = SEL_CNT; end
      OP_IRQ:  begin mode = wr_form ? M_REG_WR : M_REG_RD; sel = SEL_IRQ; end
      OP_STAT: begin mode = wr_form ? M_IDLE : M_REG_RD; sel = wr_form ? SEL_NONE : SEL_STAT; end
      default: begin mode = M_IDLE; sel = SEL_NONE; end
    endcase
  end
endmodule

// File: rtl/bap_ptr.sv
`timescale 1ns/1ps
module bap_ptr #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step_req,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-2:0] word_addr,
  output logic             take,
  output logic             finish
);
  logic [CNT_W-1:0] ptr_q;
  logic [CNT_W:0]   nxt;
  logic             active;
  logic             reach;

  assign active    = ptr_q < count;
  assign take      = step_req & active & ~clr;
  assign nxt       = {1'b0, ptr_q} + (CNT_W+1)'(2);
  assign reach     = nxt >= {1'b0, count};
  assign finish    = take & reach;
  assign word_addr = ptr_q[CNT_W-1:1];

  always_ff @(posedge clk) begin
    if (rst || clr)
      ptr_q <= '0;
    else if (take)
      ptr_q <= reach ? count : nxt[CNT_W-1:0];
  end

  // R6: the pointer never runs past the loaded count
  a_r6_ptr_bound: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= count);
  // R4: an accepted access moves the pointer by two bytes or lands it on the count
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (take && !reach) |=> ptr_q == $past(ptr_q) + CNT_W'(2));
  // R8: a command leaves the pointer at zero
  a_r8_ptr_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (ptr_q == '0));
endmodule

// File: rtl/bap_ram.sv
`timescale 1ns/1ps
module bap_ram #(
  parameter int AW = 9,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/bap_port.sv
`timescale 1ns/1ps
module bap_port
  import bap_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_valid,
  input  logic              io_cmd,
  input  logic              io_we,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_rvalid,
  output logic              eot_irq
);
  localparam int CNT_W = ADDR_W + 1;

  mode_e            mode_q, dec_mode;
  reg_e             sel_q, dec_sel;
  logic [CNT_W-1:0] cnt_q;
  logic             irq_q, rd_done_q, wr_done_q, rvalid_q, rsrc_q;
  logic [DATA_W-1:0] regout_q, ram_q, reg_mux;
  logic [ADDR_W-1:0] waddr;
  logic             cmd_stb, dat_stb, burst_rd, burst_wr, step_req, take, finish;
  logic             reg_rd_hit, reg_wr_hit, irq_clr;

  assign cmd_stb    = io_valid & io_cmd;
  assign dat_stb    = io_valid & ~io_cmd;
  assign burst_rd   = (mode_q == M_RD_BUF);
  assign burst_wr   = (mode_q == M_WR_BUF);
  assign step_req   = dat_stb & ((burst_rd & ~io_we) | (burst_wr & io_we));
  assign reg_rd_hit = dat_stb & ~io_we & (mode_q == M_REG_RD);
  assign reg_wr_hit = dat_stb &  io_we & (mode_q == M_REG_WR);
  assign irq_clr    = reg_wr_hit & (sel_q == SEL_IRQ) & io_wdata[0];

  bap_cmd_decode i_dec (
    .code (io_wdata[7:0]),
    .mode (dec_mode),
    .sel  (dec_sel)
  );

  bap_ptr #(.CNT_W(CNT_W)) i_ptr (
    .clk       (clk),
    .rst       (rst),
    .clr       (cmd_stb),
    .step_req  (step_req),
    .count     (cnt_q),
    .word_addr (waddr),
    .take      (take),
    .finish    (finish)
  );

  bap_ram #(.AW(ADDR_W), .DW(DATA_W)) i_ram (
    .clk   (clk),
    .en    (take),
    .we    (burst_wr),
    .addr  (waddr),
    .wdata (io_wdata),
    .rdata (ram_q)
  );

  always_comb begin
    case (sel_q)
      SEL_CNT:  reg_mux = DATA_W'(cnt_q);
      SEL_IRQ:  reg_mux = DATA_W'(irq_q);
      SEL_STAT: reg_mux = DATA_W'({wr_done_q, rd_done_q});
      default:  reg_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= M_IDLE;
      sel_q     <= SEL_NONE;
      cnt_q     <= '0;
      irq_q     <= 1'b0;
      rd_done_q <= 1'b0;
      wr_done_q <= 1'b0;
      rvalid_q  <= 1'b0;
      rsrc_q    <= 1'b0;
      regout_q  <= '0;
    end else begin
      rvalid_q <= (take & burst_rd) | reg_rd_hit;
      if (cmd_stb) begin
        mode_q <= dec_mode;
        sel_q  <= dec_sel;
        if (dec_mode == M_RD_BUF || dec_mode == M_WR_BUF) begin
          rd_done_q <= 1'b0;
          wr_done_q <= 1'b0;
        end
      end
      if (finish) begin
        irq_q <= 1'b1;
        if (burst_rd) rd_done_q <= 1'b1;
        else          wr_done_q <= 1'b1;
      end
      if (reg_wr_hit && sel_q == SEL_CNT) cnt_q <= io_wdata[CNT_W-1:0];
      if (irq_clr) irq_q <= 1'b0;
      if (reg_rd_hit) begin
        rsrc_q   <= 1'b0;
        regout_q <= reg_mux;
      end else if (take && burst_rd) begin
        rsrc_q <= 1'b1;
      end
    end
  end

  assign io_rdata  = rsrc_q ? ram_q : regout_q;
  assign io_rvalid = rvalid_q;
  assign eot_irq   = irq_q;

  // R5: completing a burst raises the interrupt on the next cycle
  a_r5_irq_on_finish: assert property (@(posedge clk) disable iff (rst)
    finish |=> eot_irq);
  // R7: the interrupt holds until an explicit write-one clear
  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (eot_irq && !irq_clr) |=> eot_irq);
  // R8: a command never changes the interrupt flag
  a_r8_cmd_no_irq: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |=> (eot_irq == $past(eot_irq)));
  // R6: returned data always answers a host read cycle
  a_r6_rvalid_src: assert property (@(posedge clk) disable iff (rst)
    io_rvalid |-> $past(dat_stb && !io_we));
endmodule

// File: tb/test_bap_port.sv
`timescale 1ns/1ps
module test_bap_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_valid = 1'b0, io_cmd = 1'b0, io_we = 1'b0;
  logic [15:0] io_wdata = '0;
  logic [15:0] io_rdata;
  logic        io_rvalid, eot_irq;
  int          n_run = 0, n_fail = 0;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  bap_port i_bap_port (
    .clk(clk), .rst(rst), .io_valid(io_valid), .io_cmd(io_cmd), .io_we(io_we),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid), .eot_irq(eot_irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] c);
    @(negedge clk); io_valid = 1; io_cmd = 1; io_we = 1; io_wdata = {8'h00, c};
    @(negedge clk); io_valid = 0; io_cmd = 0;
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); io_valid = 1; io_cmd = 0; io_we = 1; io_wdata = d;
    @(negedge clk); io_valid = 0;
  endtask

  task automatic rd(output logic [15:0] d, output logic v);
    @(negedge clk); io_valid = 1; io_cmd = 0; io_we = 0;
    @(negedge clk); d = io_rdata; v = io_rvalid; io_valid = 0;
  endtask

  task automatic set_count(input logic [15:0] c);
    cmd(8'hA2); wr(c);
  endtask

  task automatic get_reg(input logic [7:0] c, output logic [15:0] d);
    logic v;
    cmd(c); rd(d, v);
  endtask

  task automatic clear_irq;
    cmd(8'hA4); wr(16'h0001);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    chk("R1 irq", {15'b0, eot_irq}, 16'h0);
    chk("R1 rvalid", {15'b0, io_rvalid}, 16'h0);
    get_reg(8'h22, d); chk("R1 count", d, 16'h0);
    get_reg(8'h26, d); chk("R1 status", d, 16'h0);
  endtask

  task automatic t_count_reg;
    logic [15:0] d;
    set_count(16'hFFFF);
    get_reg(8'h22, d); chk("R2 count masked", d, 16'h03FF);
    set_count(16'h0123);
    get_reg(8'h22, d); chk("R2 count", d, 16'h0123);
  endtask

  task automatic t_burst;
    logic [15:0] d; logic v;
    set_count(16'd6);
    cmd(8'hC4);
    wr(16'hA001); wr(16'hA002);
    chk("R5 no irq early", {15'b0, eot_irq}, 16'h0);
    wr(16'hA003);
    chk("R5 irq write", {15'b0, eot_irq}, 16'h1);
    get_reg(8'h26, d); chk("R5 status write", d, 16'h0002);
    clear_irq();
    cmd(8'h44);
    for (int i = 0; i < 3; i++) begin
      rd(d, v);
      chk("R3 rvalid", {15'b0, v}, 16'h1);
      chk("R3 read data", d, 16'hA001 + 16'(i));
    end
    chk("R5 irq read", {15'b0, eot_irq}, 16'h1);
    get_reg(8'h26, d); chk("R5 status read", d, 16'h0001);
    clear_irq();
  endtask

  task automatic t_odd;
    logic [15:0] d; logic v;
    set_count(16'd5);
    cmd(8'h44);
    rd(d, v); rd(d, v);
    chk("R4 odd not done", {15'b0, eot_irq}, 16'h0);
    rd(d, v);
    chk("R4 odd third word", d, 16'hA003);
    chk("R4 odd done", {15'b0, eot_irq}, 16'h1);
    clear_irq();
  endtask

  task automatic t_after_done;
    logic [15:0] d; logic v;
    set_count(16'd4);
    cmd(8'hC4);
    wr(16'hB001); wr(16'hB002); wr(16'hBEEF);
    chk("R6 irq", {15'b0, eot_irq}, 16'h1);
    cmd(8'h44);
    rd(d, v); rd(d, v);
    rd(d, v);
    chk("R6 extra read ignored", {15'b0, v}, 16'h0);
    clear_irq();
    set_count(16'd6);
    cmd(8'h44);
    rd(d, v); chk("R6 word0", d, 16'hB001);
    rd(d, v); chk("R6 word1", d, 16'hB002);
    rd(d, v); chk("R6 word2 untouched", d, 16'hA003);
    clear_irq();
  endtask

  task automatic t_irq_clear;
    logic [15:0] d;
    set_count(16'd2);
    cmd(8'hC4); wr(16'hC001);
    cmd(8'hA4); wr(16'h0000);
    chk("R7 write zero keeps", {15'b0, eot_irq}, 16'h1);
    get_reg(8'h24, d); chk("R7 read flag", d, 16'h0001);
    cmd(8'hA4); wr(16'h0001);
    chk("R7 write one clears", {15'b0, eot_irq}, 16'h0);
  endtask

  task automatic t_abort;
    logic [15:0] d; logic v;
    set_count(16'd8);
    cmd(8'hC4); wr(16'hD001); wr(16'hD002);
    cmd(8'hC4);
    chk("R8 abort no irq", {15'b0, eot_irq}, 16'h0);
    wr(16'hE000); wr(16'hE001); wr(16'hE002);
    chk("R8 restart not done", {15'b0, eot_irq}, 16'h0);
    wr(16'hE003);
    chk("R8 restart done", {15'b0, eot_irq}, 16'h1);
    clear_irq();
    cmd(8'h44);
    rd(d, v); chk("R8 word0 rewritten", d, 16'hE000);
    clear_irq();
  endtask

  task automatic t_wrong_dir;
    logic [15:0] d; logic v;
    set_count(16'd4);
    cmd(8'hC4);
    rd(d, v); chk("R9 wrong dir read", {15'b0, v}, 16'h0);
    wr(16'hF001); wr(16'hF002);
    chk("R9 done after two writes", {15'b0, eot_irq}, 16'h1);
    clear_irq();
    set_count(16'd0);
    cmd(8'h44);
    rd(d, v); chk("R9 zero count read", {15'b0, v}, 16'h0);
    chk("R9 zero count irq", {15'b0, eot_irq}, 16'h0);
  endtask

  task automatic t_unknown;
    logic [15:0] d; logic v;
    cmd(8'h55);
    rd(d, v); chk("R10 unknown read", {15'b0, v}, 16'h0);
    wr(16'h1234);
    set_count(16'd2);
    cmd(8'h44);
    rd(d, v); chk("R10 ram untouched", d, 16'hF001);
    clear_irq();
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    begin
      logic [15:0] d; logic v;
      rd(d, v); chk("R10 no command read", {15'b0, v}, 16'h0);
    end
    t_reset();
    t_count_reg();
    t_burst();
    t_odd();
    t_after_done();
    t_irq_clear();
    t_abort();
    t_wrong_dir();
    t_unknown();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
      $finish;
    end
  end
endmodule